// File: doc/BRIEF.md
# Total-Variation Block Dispatcher

This block measures how much detail a square tile of image holds and decides which of two upscaling paths should process it. Pixels of one N×N tile arrive in row-major order, at most one per clock. At each pixel the block forms a three-point gradient: the absolute difference to the pixel on its right plus the absolute difference to the pixel directly below. It sums these gradients over the tile into an anisotropic total-variation score.

The stencil taps come from a short delay chain fed by the incoming stream. The newest pixel serves as the lower tap. A buffer of N−1 stages ends in the right-hand tap. One more stage ends in the centre tap. Only about one tile row of pixels is held. When the last pixel of a tile has been accepted, the block raises a one-cycle done pulse and presents the score with a routing flag. The flag selects the costly learned upscaler when the score is strictly above a threshold, and the cheap interpolator otherwise. Tiles may follow each other with no gap, and the input may pause at any point.

Top module: `tv_dispatch`

## Requirements
- R1: The score of a tile equals the sum, over every centre pixel (r, c) with r < N−1 and c < N−1, of |x[r][c+1] − x[r][c]| + |x[r+1][c] − x[r][c]|, with pixels read as unsigned PIX_W-bit values.
- R2: Centre positions in the last column or the last row of a tile add nothing to the score, so pixels of a neighbouring tile never enter a stencil.
- R3: route_nn is 1 when the score is strictly greater than the threshold and 0 when the score is equal to or below it.
- R4: The threshold is taken from the threshold input in the cycle that accepts the first pixel of a tile; later changes within that tile have no effect on its decision.
- R5: done is high for exactly one cycle, in the cycle after the tile's last pixel is accepted; score and route_nn change only together with done and hold their values until the next done.
- R6: A tile whose first pixel arrives in the cycle right after the previous tile's last pixel is scored on its own, with the score restarting from zero.
- R7: A cycle with in_valid low does not advance the pixel position and adds nothing to the score.
- R8: While rst_n is low, done, score and route_nn are 0.
- R9: The score width holds the largest possible tile score, (N−1)²·2·(2^PIX_W−1), without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is offered and accepted this cycle |
| in_pixel | input | PIX_W | Unsigned pixel value, row-major order |
| threshold | input | SCORE_W | Decision threshold, read at the first pixel of a tile |
| done | output | 1 | One-cycle pulse when a tile's result is ready |
| score | output | SCORE_W | Total-variation score of the last finished tile |
| route_nn | output | 1 | 1 selects the learned upscaler, 0 the interpolator |

## Verification
Each tile's result is due exactly one cycle after the clock edge that accepts its last pixel. A reference model records every accepted pixel at the rising edge. At that edge it also works out the expected done, score and route for the following cycle. The outputs are compared with the model at every falling edge, so each comparison falls in the cycle after the edge being judged, with in_valid gaps simply skipping model updates. Directed tiles are added for the cases where the result is known by hand: edge-only content, a score equal to the threshold, a threshold that changes within a tile, and the largest possible score.

// File: rtl/tv_pkg.sv
package tv_pkg;

   // Ways of forming an absolute difference
   typedef enum logic [0:0] {
      ABS_COMPARE  = 1'b0,
      ABS_NEGATE   = 1'b1
   } abs_style_e;

   // Routing targets
   typedef enum logic {
      ROUTE_INTERP = 1'b0,
      ROUTE_NN     = 1'b1
   } route_e;

   // Width that holds the worst-case tile score
   function automatic int unsigned tv_score_width(input int unsigned n, input int unsigned pw);
      longint unsigned worst;
      worst = longint'(n - 1) * longint'(n - 1) * 2 * ((longint'(1) << pw) - 1);
      return $clog2(worst + 1);
   endfunction

endpackage

// File: rtl/tv_tap_chain.sv
module tv_tap_chain #(
   parameter int unsigned N     = 32,
   parameter int unsigned PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic [PIX_W-1:0] pix_in,
   output logic [PIX_W-1:0] tap_right,
   output logic [PIX_W-1:0] tap_center
);

   // stage k holds the pixel accepted k+1 positions earlier
   logic [PIX_W-1:0] stg [N];

   generate
      for (genvar k = 0; k < N; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[k] <= '0;
            end else if (shift_en) begin
               if (k == 0) stg[k] <= pix_in;
               else        stg[k] <= stg[k-1];
            end
         end
      end
   endgenerate

   // N-1 positions back: right neighbour of the centre; N back: the centre
   assign tap_right  = stg[N-2];
   assign tap_center = stg[N-1];

   assert_chain_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (stg[0] == $past(pix_in)));

   assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> ($stable(tap_center) && $stable(tap_right)));

endmodule

// File: rtl/tv_grad.sv
module tv_grad #(
   parameter int unsigned       PIX_W     = 8,
   parameter tv_pkg::abs_style_e ABS_STYLE = tv_pkg::ABS_COMPARE
) (
   input  logic [PIX_W-1:0] center,
   input  logic [PIX_W-1:0] right,
   input  logic [PIX_W-1:0] down,
   output logic [PIX_W:0]   grad
);

   logic [PIX_W-1:0] d_right;
   logic [PIX_W-1:0] d_down;

   generate
      if (ABS_STYLE == tv_pkg::ABS_COMPARE) begin : g_cmp
         always_comb begin
            d_right = (right >= center) ? (right - center) : (center - right);
            d_down  = (down  >= center) ? (down  - center) : (center - down);
         end
      end else begin : g_neg
         logic [PIX_W:0] s_right;
         logic [PIX_W:0] s_down;
         always_comb begin
            s_right = {1'b0, right} - {1'b0, center};
            s_down  = {1'b0, down}  - {1'b0, center};
            d_right = s_right[PIX_W] ? PIX_W'(-s_right) : s_right[PIX_W-1:0];
            d_down  = s_down[PIX_W]  ? PIX_W'(-s_down)  : s_down[PIX_W-1:0];
         end
      end
   endgenerate

   assign grad = {1'b0, d_right} + {1'b0, d_down};

endmodule

// File: rtl/tv_accum.sv
module tv_accum #(
   parameter int unsigned N       = 32,
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned SCORE_W = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PIX_W:0]     grad,
   input  logic [SCORE_W-1:0] threshold,
   output logic               done,
   output logic [SCORE_W-1:0] score,
   output logic               route_nn
);

   localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   logic [CW-1:0]      col;
   logic [CW-1:0]      row;
   logic [SCORE_W-1:0] acc;
   logic [SCORE_W-1:0] thr_q;
   logic               at_last_col;
   logic               at_last_row;
   logic               at_first;
   logic               take_grad;
   logic [SCORE_W:0]   acc_sum;
   tv_pkg::route_e     route_sel;

   always_comb begin
      at_last_col = (col == LAST);
      at_last_row = (row == LAST);
      at_first    = (row == '0) && (col == '0);
      // the incoming pixel is the lower tap; centre sits one row up
      take_grad   = (row != '0) && !at_last_col;
      acc_sum     = (at_first ? '0 : {1'b0, acc})
                  + (take_grad ? (SCORE_W+1)'(grad) : '0);
      route_sel   = (acc_sum[SCORE_W-1:0] > thr_q) ? tv_pkg::ROUTE_NN : tv_pkg::ROUTE_INTERP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col      <= '0;
         row      <= '0;
         acc      <= '0;
         thr_q    <= '0;
         done     <= 1'b0;
         score    <= '0;
         route_nn <= 1'b0;
      end else begin
         done <= 1'b0;
         if (in_valid) begin
            acc <= acc_sum[SCORE_W-1:0];
            if (at_first) thr_q <= threshold;
            if (at_last_col) begin
               col <= '0;
               row <= at_last_row ? '0 : row + 1'b1;
            end else begin
               col <= col + 1'b1;
            end
            if (at_last_col && at_last_row) begin
               done     <= 1'b1;
               score    <= acc_sum[SCORE_W-1:0];
               route_nn <= (route_sel == tv_pkg::ROUTE_NN);
            end
         end
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !acc_sum[SCORE_W]);

   assert_edge_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && at_last_col) |=> (acc == $past(acc)));

   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(col) && $stable(row) && $stable(acc)));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_strict_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (route_nn == (score > thr_q)));

endmodule

// File: rtl/tv_dispatch.sv
module tv_dispatch #(
   parameter int unsigned        N         = 32,
   parameter int unsigned        PIX_W     = 8,
   parameter int unsigned        SCORE_W   = tv_pkg::tv_score_width(N, PIX_W),
   parameter tv_pkg::abs_style_e ABS_STYLE = tv_pkg::ABS_COMPARE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PIX_W-1:0]   in_pixel,
   input  logic [SCORE_W-1:0] threshold,
   output logic               done,
   output logic [SCORE_W-1:0] score,
   output logic               route_nn
);

   generate
      if (N < 2) begin : g_bad_side
         $error("tv_dispatch: tile side N must be at least 2");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("tv_dispatch: PIX_W must be at least 1");
      end
      if (SCORE_W < tv_pkg::tv_score_width(N, PIX_W) || SCORE_W <= PIX_W) begin : g_bad_score
         $error("tv_dispatch: SCORE_W too narrow for the worst-case score");
      end
   endgenerate

   logic [PIX_W-1:0] tap_right;
   logic [PIX_W-1:0] tap_center;
   logic [PIX_W:0]   grad;

   tv_tap_chain #(.N(N), .PIX_W(PIX_W)) i_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (in_valid),
      .pix_in     (in_pixel),
      .tap_right  (tap_right),
      .tap_center (tap_center)
   );

   tv_grad #(.PIX_W(PIX_W), .ABS_STYLE(ABS_STYLE)) i_grad (
      .center (tap_center),
      .right  (tap_right),
      .down   (in_pixel),
      .grad   (grad)
   );

   tv_accum #(.N(N), .PIX_W(PIX_W), .SCORE_W(SCORE_W)) i_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .grad      (grad),
      .threshold (threshold),
      .done      (done),
      .score     (score),
      .route_nn  (route_nn)
   );

   assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(score) && $stable(route_nn)));

endmodule

// File: tb/test_tv_dispatch.sv
module test_tv_dispatch;

   localparam int N  = 8;
   localparam int PW = 8;
   localparam int MAXS = (N - 1) * (N - 1) * 2 * 255;
   localparam int SW = $clog2(MAXS + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [PW-1:0] in_pixel = '0;
   logic [SW-1:0] threshold = '0;
   logic          done;
   logic [SW-1:0] score;
   logic          route_nn;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tv_dispatch #(.N(N), .PIX_W(PW)) i_tv_dispatch (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
      .threshold(threshold), .done(done), .score(score), .route_nn(route_nn)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int  pix [N][N];
   int  m_cnt = 0;
   int  m_thr = 0;
   bit  exp_done = 0;
   int  exp_score = 0;
   bit  exp_route = 0;

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; exp_done = 0; exp_score = 0; exp_route = 0;
      end else begin
         exp_done = 0;
         if (in_valid) begin
            if (m_cnt == 0) m_thr = int'(threshold);
            pix[m_cnt / N][m_cnt % N] = int'(in_pixel);
            m_cnt++;
            if (m_cnt == N * N) begin
               int s;
               s = 0;
               for (int r = 0; r < N - 1; r++)
                  for (int c = 0; c < N - 1; c++)
                     s += absd(pix[r][c+1], pix[r][c]) + absd(pix[r+1][c], pix[r][c]);
               exp_score = s;
               exp_route = (s > m_thr);
               exp_done  = 1;
               m_cnt     = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         if (!rst_n) begin
            chk(done == 0 && score == 0 && route_nn == 0, "R8 reset outputs",
                int'(score) + int'(done) + int'(route_nn), 0);
         end else begin
            chk(done == exp_done, "R5 done timing", int'(done), int'(exp_done));
            chk(int'(score) == exp_score, "R1 score", int'(score), exp_score);
            chk(route_nn == exp_route, "R3 route", int'(route_nn), int'(exp_route));
         end
      end
   end

   // ---------------- stimulus ----------------
   int src [N][N];

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_block(input int thr0, input int thr1, input int stall_pct);
      for (int k = 0; k < N * N; k++) begin
         while (($urandom % 100) < stall_pct) idle();
         @(negedge clk);
         in_valid  = 1'b1;
         in_pixel  = PW'(src[k / N][k % N]);
         threshold = SW'((k == 0) ? thr0 : thr1);
      end
   endtask

   task automatic fill_zero();
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) src[r][c] = 0;
   endtask

   task automatic fill_rand();
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) src[r][c] = int'($urandom % 256);
   endtask

   // after send_block: one idle cycle, then the result is visible
   task automatic expect_result(input int s, input bit rt, input string req);
      idle();
      chk(done == 1'b1, req, int'(done), 1);
      chk(int'(score) == s, req, int'(score), s);
      chk(route_nn == rt, req, int'(route_nn), int'(rt));
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R3: one bright pixel at the origin gives score 20; equal threshold -> interpolator
      fill_zero(); src[0][0] = 10;
      send_block(20, 20, 0);
      expect_result(20, 1'b0, "R3 equal threshold");
      // R3: threshold one below -> learned upscaler
      send_block(19, 19, 0);
      expect_result(20, 1'b1, "R3 above threshold");

      // R2: only the bottom-right corner is nonzero -> no stencil sees it
      fill_zero(); src[N-1][N-1] = 255;
      send_block(0, 0, 0);
      expect_result(0, 1'b0, "R2 corner skipped");
      // R2: alternating last row and last column, own-row/col edge terms skipped
      fill_zero();
      for (int c = 0; c < N; c++) src[N-1][c] = (c % 2) ? 200 : 0;
      for (int r = 0; r < N - 1; r++) src[r][N-1] = (r % 2) ? 0 : 90;
      send_block(100, 100, 0);
      idle();

      // R4: threshold changes after the first pixel; decision uses 19
      fill_zero(); src[0][0] = 10;
      send_block(19, 1000, 0);
      expect_result(20, 1'b1, "R4 threshold sampled at start");

      // R9: checkerboard gives the largest score
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) src[r][c] = ((r + c) % 2) ? 255 : 0;
      send_block(MAXS - 1, 0, 0);
      expect_result(MAXS, 1'b1, "R9 maximum score");

      // R6: back-to-back random tiles with no gap
      for (int b = 0; b < 4; b++) begin
         fill_rand();
         send_block(int'($urandom % 12000), int'($urandom % 12000), 0);
      end
      idle();
      idle();

      // R7: random stalls inside tiles
      for (int b = 0; b < 4; b++) begin
         fill_rand();
         send_block(int'($urandom % 12000), int'($urandom % 12000), 35);
      end
      // R6 with R7: stalls and back-to-back mixed, low-detail tiles
      for (int b = 0; b < 3; b++) begin
         for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) src[r][c] = 100 + int'($urandom % 4);
         send_block(int'($urandom % 300), 0, 10);
      end
      repeat (4) idle();

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule